// File: doc/BRIEF.md
# Single-Rank SDRAM Controller with Range-Select Timing

This block sits between a simple host request port and one rank of 32-bit SDRAM. It accepts one single-word read or write at a time. For each request it opens the row, issues the column command with auto-precharge, and returns a one-cycle acknowledge. A small control word sets it up. One bit picks a CAS latency of 2 or 3. Four one-bit selects choose between a short and a long clock count for row-to-column delay, write recovery, precharge time and refresh-to-active time. One bit arms a mode-register load. One bit starts the initial precharge and reads back as busy until the precharge completes.

A free-running timer raises a refresh request at a fixed interval. The block serves pending work only while it is idle, in this order: the init precharge, then refresh, then the host. Once the mode bit is armed, the next host request becomes a LOAD MODE REGISTER command instead of a row access, and the host word address supplies the mode word. That command is held back until enough auto-refresh commands have been issued since the last init precharge. The arm bit drops by itself once the command has gone out.

Top module: `sdram_ctl`

## Requirements
- R1: Reset state. While reset is held, and afterwards until work arrives, the block drives NOP on {cs_n,ras_n,cas_n,we_n} = 0111, `ack` = 0, `sd_dq_oe` = 0 and `cfg_rdata` = 0. The other command codes are: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R2: Control word fields. Bit 0 selects CAS latency (0 gives 2, 1 gives 3). Bit 1 selects tRCD, bit 2 tWR and bit 3 tRP, each as 0 = T25_CLK and 1 = T50_CLK. Bit 4 selects tRC as 0 = T75_CLK and 1 = T100_CLK. Bit 5 is the mode arm bit. Bit 6 is init, write 1 to start. `cfg_rdata` returns bits 4:0 as written, plus the live arm bit and the live busy bit.
- R3: Writing 1 to bit 6 makes the busy bit read 1 on the next cycle. The block then issues PRECHARGE with sd_addr[10] = 1, and the busy bit clears exactly tRP cycles after that command. Writing 0 to bit 6 issues no PRECHARGE.
- R4: The column command follows ACTIVE by exactly tRCD cycles. After READ, the next command waits at least CL+tRP cycles. After WRITE it waits at least tWR+tRP, after PRECHARGE at least tRP, after AUTO REFRESH at least tRC, and after LOAD MODE at least TMRD_CLK.
- R5: A read issues READ with sd_addr[10] = 1 and captures `sd_dq_in` exactly CL cycles after READ. `rsp_rdata` holds that word when `ack` pulses for one cycle, tRCD+CL cycles after ACTIVE.
- R6: A write issues WRITE with sd_addr[10] = 1 and `sd_dq_out` = `req_wdata`. `sd_dq_oe` is high in that cycle only. `ack` pulses in the same cycle, tRCD cycles after ACTIVE.
- R7: Word-address mapping. Column = req_addr[COLW-1:0], bank = the next BAW bits, row = the top RW bits. ACTIVE drives the row on `sd_addr` and the bank on `sd_ba`.
- R8: A refresh request is raised every REF_INTERVAL cycles. AUTO REFRESH issues only from idle, never between ACTIVE and its column command, so REF-to-REF spacing stays within REF_INTERVAL plus one access.
- R9: With the arm bit set, the next host request issues LOAD MODE with sd_addr = req_addr[RW-1:0] and no ACTIVE. `ack` pulses in the same cycle and the arm bit reads 0 from then on. The mode word is 0x22 for CAS latency 2 and 0x32 for latency 3 (sequential, burst four).
- R10: LOAD MODE is not issued before MIN_REFS AUTO REFRESH commands have followed the most recent init PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word write value |
| cfg_rdata | output | 7 | Control word with live arm and busy bits |
| req | input | 1 | Host request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Host word address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data, valid with ack |
| ack | output | 1 | One-cycle transfer acknowledge |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | BAW | SDRAM bank address |
| sd_addr | output | RW | SDRAM address bus |
| sd_dq_out | output | DW | Write data to SDRAM |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DW | Read data from SDRAM |

## Verification
A wrong wait counter or a wrong latency select shows up on the very next access. The column command lands one cycle early or late after ACTIVE. Or the read sample misses the single cycle in which the bench's memory model drives valid data, so `rsp_rdata` carries a marker word instead of what was written. A broken refresh or init path shows up within one refresh interval: a REF gap grows too long, a command appears between ACTIVE and its column command, or the busy bit clears on the wrong cycle. A bad mode gate shows up as LOAD MODE issued before enough refreshes have been counted since the last PRECHARGE.

// File: rtl/sdram_ctl.sv
module sdram_ctl #(
  parameter int DW           = 32,
  parameter int RW           = 12,
  parameter int BAW          = 2,
  parameter int COLW         = 8,
  parameter int T25_CLK      = 1,
  parameter int T50_CLK      = 2,
  parameter int T75_CLK      = 3,
  parameter int T100_CLK     = 4,
  parameter int TMRD_CLK     = 2,
  parameter int REF_INTERVAL = 780,
  parameter int MIN_REFS     = 8,
  localparam int AW          = RW + BAW + COLW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [6:0]     cfg_wdata,
  output logic [6:0]     cfg_rdata,
  input  logic           req,
  input  logic           req_we,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic [DW-1:0]  rsp_rdata,
  output logic           ack,
  output logic           sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic [BAW-1:0] sd_ba,
  output logic [RW-1:0]  sd_addr,
  output logic [DW-1:0]  sd_dq_out,
  output logic           sd_dq_oe,
  input  logic [DW-1:0]  sd_dq_in
);

  localparam int TMAX = 2 * T50_CLK + T100_CLK + TMRD_CLK + 4;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RTW  = $clog2(REF_INTERVAL + 1);
  localparam int RSW  = $clog2(MIN_REFS + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_REF, S_MRS, S_ACT, S_CL, S_WREC, S_RCV} st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [3:0]     cmd_q;
  logic [4:0]     tsel;
  logic           mode_arm, init_busy, ref_pend;
  logic [RTW-1:0] ref_tmr;
  logic [RSW-1:0] ref_since;

  assign cfg_rdata = {init_busy, mode_arm, tsel};
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  wire [CW-1:0] t_cl  = tsel[0] ? CW'(3) : CW'(2);
  wire [CW-1:0] t_rcd = tsel[1] ? CW'(T50_CLK) : CW'(T25_CLK);
  wire [CW-1:0] t_wr  = tsel[2] ? CW'(T50_CLK) : CW'(T25_CLK);
  wire [CW-1:0] t_rp  = tsel[3] ? CW'(T50_CLK) : CW'(T25_CLK);
  wire [CW-1:0] t_rc  = tsel[4] ? CW'(T100_CLK) : CW'(T75_CLK);

  wire [COLW-1:0] col  = req_addr[COLW-1:0];
  wire [BAW-1:0]  bank = req_addr[COLW+BAW-1:COLW];
  wire [RW-1:0]   row  = req_addr[AW-1:COLW+BAW];
  wire [RW-1:0]   ca   = RW'(1024) | RW'(col);

  wire idle    = (state == S_IDLE);
  wire refs_ok = (ref_since == RSW'(MIN_REFS));
  wire go_pre  = idle && init_busy;
  wire go_ref  = idle && !init_busy && ref_pend;
  wire go_mrs  = idle && !init_busy && !ref_pend && req && mode_arm && refs_ok;
  wire go_act  = idle && !init_busy && !ref_pend && req && !mode_arm;
  wire pre_end = (state == S_PRE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsel      <= '0;
      mode_arm  <= 1'b0;
      init_busy <= 1'b0;
    end else begin
      if (pre_end) init_busy <= 1'b0;
      if (cfg_we) begin
        tsel     <= cfg_wdata[4:0];
        mode_arm <= cfg_wdata[5];
        if (cfg_wdata[6]) init_busy <= 1'b1;
      end
      if (go_mrs) mode_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_tmr   <= RTW'(REF_INTERVAL - 1);
      ref_pend  <= 1'b0;
      ref_since <= '0;
    end else begin
      if (go_ref) ref_pend <= 1'b0;
      if (ref_tmr == '0) begin
        ref_tmr  <= RTW'(REF_INTERVAL - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
      end
      if (go_pre) ref_since <= '0;
      else if (go_ref && !refs_ok) ref_since <= ref_since + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cmd_q     <= C_NOP;
      ack       <= 1'b0;
      sd_dq_oe  <= 1'b0;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      rsp_rdata <= '0;
    end else begin
      cmd_q    <= C_NOP;
      ack      <= 1'b0;
      sd_dq_oe <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go_pre) begin
            cmd_q   <= C_PRE;
            sd_addr <= RW'(1024);
            cnt     <= t_rp - 1'b1;
            state   <= S_PRE;
          end else if (go_ref) begin
            cmd_q <= C_REF;
            cnt   <= t_rc - 1'b1;
            state <= S_REF;
          end else if (go_mrs) begin
            cmd_q   <= C_MRS;
            sd_ba   <= '0;
            sd_addr <= req_addr[RW-1:0];
            ack     <= 1'b1;
            cnt     <= CW'(TMRD_CLK - 1);
            state   <= S_MRS;
          end else if (go_act) begin
            cmd_q   <= C_ACT;
            sd_ba   <= bank;
            sd_addr <= row;
            cnt     <= t_rcd - 1'b1;
            state   <= S_ACT;
          end
        end
        S_ACT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sd_addr <= ca;
            sd_ba   <= bank;
            if (req_we) begin
              cmd_q     <= C_WR;
              sd_dq_out <= req_wdata;
              sd_dq_oe  <= 1'b1;
              ack       <= 1'b1;
              cnt       <= t_wr + t_rp - 1'b1;
              state     <= S_WREC;
            end else begin
              cmd_q <= C_RD;
              cnt   <= t_cl - 1'b1;
              state <= S_CL;
            end
          end
        end
        S_CL: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            rsp_rdata <= sd_dq_in;
            ack       <= 1'b1;
            cnt       <= t_rp - 1'b1;
            state     <= S_RCV;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= S_IDLE;
        end
      endcase
    end
  end

  logic [CW-1:0] act_age;
  always_ff @(posedge clk) begin
    if (!rst_n) act_age <= '0;
    else if (cmd_q == C_ACT) act_age <= CW'(1);
    else if (act_age != '1) act_age <= act_age + 1'b1;
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R5
  AST_INIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> $past(state) == S_PRE); // R3
  AST_COL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> (act_age >= CW'(T25_CLK) && act_age <= CW'(T50_CLK))); // R4
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> cmd_q == C_WR); // R6
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS) |-> !mode_arm); // R9
  AST_REF_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF) |-> $past(state) == S_IDLE); // R8

endmodule

// File: tb/sdram_ctl_test.sv
module sdram_ctl_test;
  localparam int REFI = 40;
  localparam int MINR = 8;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [6:0] cfg_wdata = '0; logic [6:0] cfg_rdata;
  logic req = 0, req_we = 0; logic [21:0] req_addr = '0; logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata; logic ack;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba; logic [11:0] sd_addr; logic [31:0] sd_dq_out; logic sd_dq_oe;
  logic [31:0] sd_dq_in = '0;

  sdram_ctl #(.REF_INTERVAL(REFI), .MIN_REFS(MINR)) uut (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .req, .req_we, .req_addr,
    .req_wdata, .rsp_rdata, .ack, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n,
    .sd_ba, .sd_addr, .sd_dq_out, .sd_dq_oe, .sd_dq_in);

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0; bit done = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int f_rcd(input logic [4:0] c); return c[1] ? 2 : 1; endfunction
  function automatic int f_cl (input logic [4:0] c); return c[0] ? 3 : 2; endfunction
  function automatic int f_wr (input logic [4:0] c); return c[2] ? 2 : 1; endfunction
  function automatic int f_rp (input logic [4:0] c); return c[3] ? 2 : 1; endfunction
  function automatic int f_rc (input logic [4:0] c); return c[4] ? 4 : 3; endfunction

  logic [21:0] cur_addr; logic [31:0] cur_data; bit cur_we, cur_mode;
  logic [4:0] cfg_live = '0;
  int cyc = 0, last_cyc = -1, need = 0, act_cyc = 0, pre_cyc = 0, mrs_cyc = -1;
  int rd_due = -1, last_ref = -1, refs_since_pre = 0;
  int pre_count = 0, act_count = 0, mrs_count = 0, ref_count = 0;
  bit after_act = 0, prev_init = 0;
  logic [11:0] act_row; logic [7:0] rd_idx;
  logic [31:0] mem [256];

  always @(posedge clk) begin
    logic [3:0] cmd;
    #1;
    cyc++;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      if (cmd != WR) chk(!sd_dq_oe, "R6 oe outside write", sd_dq_oe, 0);
      if (cmd != NOP) begin
        if (last_cyc >= 0) chk(cyc - last_cyc >= need, "R4 command spacing", cyc - last_cyc, need);
        if (after_act) chk(cmd == RD || cmd == WR, "R8 command between ACT and column", cmd, RD);
        after_act = 0;
        case (cmd)
          ACT: begin
            act_count++;
            chk(sd_addr == cur_addr[21:10], "R7 row", sd_addr, cur_addr[21:10]);
            chk(sd_ba == cur_addr[9:8], "R7 bank", sd_ba, cur_addr[9:8]);
            act_cyc = cyc; act_row = sd_addr; after_act = 1; need = f_rcd(cfg_live);
          end
          RD, WR: begin
            chk(cyc - act_cyc == f_rcd(cfg_live), "R4 tRCD", cyc - act_cyc, f_rcd(cfg_live));
            chk(sd_addr == (12'h400 | 12'(cur_addr[7:0])), "R7 column", sd_addr, 12'h400 | 12'(cur_addr[7:0]));
            rd_idx = {sd_ba, act_row[1:0], sd_addr[3:0]};
            if (cmd == RD) begin
              rd_due = cyc + f_cl(cfg_live) - 1; need = f_cl(cfg_live) + f_rp(cfg_live);
            end else begin
              mem[rd_idx] = sd_dq_out;
              chk(sd_dq_oe && sd_dq_out == cur_data, "R6 write data", sd_dq_out, cur_data);
              need = f_wr(cfg_live) + f_rp(cfg_live);
            end
          end
          PRE: begin
            chk(sd_addr[10], "R3 precharge all", sd_addr, 12'h400);
            pre_count++; pre_cyc = cyc; refs_since_pre = 0; need = f_rp(cfg_live);
          end
          REF: begin
            if (last_ref >= 0) chk(cyc - last_ref <= REFI + 16, "R8 refresh gap", cyc - last_ref, REFI + 16);
            last_ref = cyc; refs_since_pre++; ref_count++; need = f_rc(cfg_live);
          end
          MRS: begin
            chk(refs_since_pre >= MINR, "R10 refreshes before mode", refs_since_pre, MINR);
            chk(sd_addr == cur_addr[11:0], "R9 mode word", sd_addr, cur_addr[11:0]);
            mrs_count++; mrs_cyc = cyc; need = 2;
          end
          default: chk(0, "R1 illegal command", cmd, NOP);
        endcase
        last_cyc = cyc;
      end
      if (ack) begin
        if (cur_mode) chk(cyc == mrs_cyc, "R9 mode ack", cyc, mrs_cyc);
        else if (cur_we) chk(cyc - act_cyc == f_rcd(cfg_live), "R6 write ack", cyc - act_cyc, f_rcd(cfg_live));
        else chk(cyc - act_cyc == f_rcd(cfg_live) + f_cl(cfg_live), "R5 read ack",
                 cyc - act_cyc, f_rcd(cfg_live) + f_cl(cfg_live));
      end
      if (prev_init && !cfg_rdata[6]) chk(cyc - pre_cyc == f_rp(cfg_live), "R3 busy clear", cyc - pre_cyc, f_rp(cfg_live));
      prev_init = cfg_rdata[6];
    end
    sd_dq_in = (cyc == rd_due) ? mem[rd_idx] : (32'hBAD0_0000 ^ 32'(cyc));
    if (cfg_we) cfg_live = cfg_wdata[4:0];
  end

  task automatic cfg_write(input logic [6:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(input bit we, input bit mode, input logic [21:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    int w;
    @(negedge clk);
    cur_addr = a; cur_data = d; cur_we = we; cur_mode = mode;
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    w = 0;
    do begin @(negedge clk); w++; end while (!ack && w < 1000);
    chk(ack, "R5 ack arrives", w, 0);
    q = rsp_rdata; req = 0;
  endtask

  task automatic do_init;
    int w;
    cfg_write({2'b10, cfg_live});
    chk(cfg_rdata[6], "R3 busy after write", cfg_rdata, 7'h40);
    w = 0;
    while (cfg_rdata[6] && w < 30) begin @(negedge clk); w++; end
    chk(!cfg_rdata[6], "R3 busy clears", cfg_rdata, 0);
  endtask

  initial begin
    logic [31:0] q;
    int pc, rc;
    repeat (4) @(negedge clk);
    chk(cfg_rdata == 0 && !ack && !sd_dq_oe, "R1 reset outputs", {cfg_rdata, ack, sd_dq_oe}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 reset NOP", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == 0, "R1 after reset", cfg_rdata, 0);
    do_init();
    pc = pre_count;
    cfg_write(7'h00);
    repeat (10) @(negedge clk);
    chk(pre_count == pc, "R3 init 0 ignored", pre_count, pc);
    cfg_write(7'h15); chk(cfg_rdata == 7'h15, "R2 readback", cfg_rdata, 7'h15);
    cfg_write(7'h0A); chk(cfg_rdata == 7'h0A, "R2 readback", cfg_rdata, 7'h0A);
    for (int m = 0; m < 2; m++) begin
      do_init();
      cfg_write(m ? 7'h21 : 7'h20);
      chk(cfg_rdata[5], "R2 arm readback", cfg_rdata, 7'h20);
      pc = act_count; rc = mrs_count;
      access(0, 1, m ? 22'h32 : 22'h22, 0, q);
      @(negedge clk);
      chk(!cfg_rdata[5], "R9 arm clears", cfg_rdata, 0);
      chk(mrs_count == rc + 1 && act_count == pc, "R9 mode instead of access", mrs_count, rc + 1);
    end
    for (int c = 0; c < 32; c++) begin
      cfg_write(7'(c));
      for (int i = 0; i < 4; i++) begin
        logic [21:0] a;
        logic [31:0] d;
        a = {12'(c * 37 + i * 5 + 12'h800), 2'(i), 8'((c * 4 + i) % 16)};
        d = 32'h1234_0000 + 32'(c * 16 + i) * 32'h0101;
        access(1, 0, a, d, q);
        access(0, 0, a, 0, q);
        chk(q == d, "R5 read data", q, d);
      end
    end
    rc = ref_count;
    repeat (5 * REFI) @(negedge clk);
    chk(ref_count - rc >= 4, "R8 idle refresh rate", ref_count - rc, 4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule